// File: doc/BRIEF.md
# Read-Modify-Write Shift and Flag Unit

This block computes the value and the status flags for the single-operand memory operations of an 8-bit processor core: shift left, rotate right through carry, step down by one, step up by one, and a bit test of a memory byte against the accumulator. The sequencer that fetches the operand presents it together with the accumulator, the current N, V, Z and C flags and an operation code. One cycle later the block returns the byte to store, a store enable and the new flag values.

The bit test differs from the other operations. It takes N and V straight from bits 7 and 6 of the memory byte. It sets Z when the memory byte ANDed with the accumulator is zero. It stores nothing. An operation code with no defined meaning passes the flags through unchanged and does not request a store. Address generation and bus sequencing belong to the caller.

Top module: `rmw_flag_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, res_valid, res_we, res_data and all four flag outputs are 0.
- R2: A request accepted on a clock edge (req_valid high) makes res_valid high for exactly the next cycle. res_valid is low in every cycle that does not follow an accepted request.
- R3: Code 0 (shift left) returns the operand shifted left with bit 0 cleared. C gets the old bit 7, N gets result bit 7 and Z is set for a zero result. V is unchanged and res_we is 1.
- R4: Code 1 (rotate right) returns {C_in, operand[7:1]}. C gets the old bit 0, N gets result bit 7 and Z is set for a zero result. V is unchanged and res_we is 1.
- R5: Code 2 (decrement) returns the operand minus one, modulo 256. N and Z follow the result, C and V are unchanged, and res_we is 1.
- R6: Code 3 (increment) returns the operand plus one, modulo 256. N and Z follow the result, C and V are unchanged, and res_we is 1.
- R7: Code 4 (bit test) sets N to operand bit 7 and V to operand bit 6. Z is 1 exactly when operand AND accumulator is zero, and C is unchanged. res_we is 0 and res_data equals the unmodified operand.
- R8: Codes 5, 6 and 7 return all four flags exactly as they came in. res_we is 0 and res_data equals the operand.
- R9: In a cycle with no request, res_we is 0 on the following cycle, while res_data and the flag outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request, sampled on the clock edge |
| req_op | input | 3 | Operation code (0 shl, 1 ror, 2 dec, 3 inc, 4 bit test) |
| mem_in | input | 8 | Memory operand |
| acc_in | input | 8 | Accumulator value |
| flag_n_in | input | 1 | Incoming negative flag |
| flag_v_in | input | 1 | Incoming overflow flag |
| flag_z_in | input | 1 | Incoming zero flag |
| flag_c_in | input | 1 | Incoming carry flag |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Byte to write back |
| res_we | output | 1 | Write-back enable |
| flag_n_out | output | 1 | Updated negative flag |
| flag_v_out | output | 1 | Updated overflow flag |
| flag_z_out | output | 1 | Updated zero flag |
| flag_c_out | output | 1 | Updated carry flag |

## Verification
The assertions check on every cycle the parts of the behaviour that do not depend on particular data values. These are the one-cycle strobe timing, the absence of a store after a bit test or an undefined code, the carry and V preservation of the step operations, the zero bit and carry taken by the shift, and the holding of outputs between requests. The directed scenarios exercise the data paths at their edges: wrap of 0x00 and 0xFF, a result that becomes zero, carry moving into bit 7 of a rotate, and bit tests where the AND is empty and where it is not. Only these scenarios can show that each result byte and the Z and N values are correct.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 3'd0,
    OP_ROR  = 3'd1,
    OP_DEC  = 3'd2,
    OP_INC  = 3'd3,
    OP_BTST = 3'd4
  } rmw_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } rmw_flags_t;
endpackage

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit #(
  parameter int unsigned W = 8
) (
  input  logic         rotate,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);
  always_comb begin
    if (rotate) begin
      result    = {carry_in, operand[W-1:1]};
      carry_out = operand[0];
    end else begin
      result    = {operand[W-2:0], 1'b0};
      carry_out = operand[W-1];
    end
  end

  always_comb begin
    if (!rotate) assert (result[0] == 1'b0) else $error("a_r3_shl_clears_lsb");
  end
endmodule

// File: rtl/rmw_step_unit.sv
module rmw_step_unit #(
  parameter int unsigned W = 8
) (
  input  logic         down,
  input  logic [W-1:0] operand,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (down) result = operand - ONE;
    else      result = operand + ONE;
  end
endmodule

// File: rtl/rmw_bit_unit.sv
module rmw_bit_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] operand,
  input  logic [W-1:0] acc,
  output logic         n_out,
  output logic         v_out,
  output logic         z_out
);
  always_comb begin
    n_out = operand[W-1];
    v_out = operand[W-2];
    z_out = ((operand & acc) == '0);
  end
endmodule

// File: rtl/rmw_flag_unit.sv
module rmw_flag_unit
  import rmw_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [2:0]   req_op,
  input  logic [W-1:0] mem_in,
  input  logic [W-1:0] acc_in,
  input  logic         flag_n_in,
  input  logic         flag_v_in,
  input  logic         flag_z_in,
  input  logic         flag_c_in,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_we,
  output logic         flag_n_out,
  output logic         flag_v_out,
  output logic         flag_z_out,
  output logic         flag_c_out
);
  logic [W-1:0] sh_res, st_res;
  logic         sh_c;
  logic         bt_n, bt_v, bt_z;
  logic         is_ror, is_dec;

  logic [W-1:0] data_d, data_q;
  logic         we_d, we_q, valid_q;
  rmw_flags_t   flags_in, flags_d, flags_q;

  assign is_ror   = (req_op == OP_ROR);
  assign is_dec   = (req_op == OP_DEC);
  assign flags_in = '{n: flag_n_in, v: flag_v_in, z: flag_z_in, c: flag_c_in};

  rmw_shift_unit #(.W(W)) u_shift (
    .rotate(is_ror), .operand(mem_in), .carry_in(flag_c_in),
    .result(sh_res), .carry_out(sh_c)
  );

  rmw_step_unit #(.W(W)) u_step (
    .down(is_dec), .operand(mem_in), .result(st_res)
  );

  rmw_bit_unit #(.W(W)) u_bit (
    .operand(mem_in), .acc(acc_in),
    .n_out(bt_n), .v_out(bt_v), .z_out(bt_z)
  );

  // next-state decode
  always_comb begin
    data_d  = mem_in;
    we_d    = 1'b0;
    flags_d = flags_in;
    case (req_op)
      OP_SHL, OP_ROR: begin
        data_d    = sh_res;
        we_d      = 1'b1;
        flags_d.n = sh_res[W-1];
        flags_d.z = (sh_res == '0);
        flags_d.c = sh_c;
      end
      OP_DEC, OP_INC: begin
        data_d    = st_res;
        we_d      = 1'b1;
        flags_d.n = st_res[W-1];
        flags_d.z = (st_res == '0);
      end
      OP_BTST: begin
        flags_d.n = bt_n;
        flags_d.v = bt_v;
        flags_d.z = bt_z;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= req_valid;
      we_q    <= req_valid & we_d;
      if (req_valid) begin
        data_q  <= data_d;
        flags_q <= flags_d;
      end
    end
  end

  assign res_valid  = valid_q;
  assign res_we     = we_q;
  assign res_data   = data_q;
  assign flag_n_out = flags_q.n;
  assign flag_v_out = flags_q.v;
  assign flag_z_out = flags_q.z;
  assign flag_c_out = flags_q.c;

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r2_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r3_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SHL) |=> (!res_data[0] && flag_c_out == $past(mem_in[W-1])));
  a_r4_ror_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_ROR) |=> (res_data[W-1] == $past(flag_c_in) && flag_c_out == $past(mem_in[0])));
  a_r5_step_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_DEC || req_op == OP_INC)) |=>
      (flag_c_out == $past(flag_c_in) && flag_v_out == $past(flag_v_in) && res_we));
  a_r7_btst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_BTST) |=> (!res_we && res_data == $past(mem_in)));
  a_r8_undef_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > OP_BTST) |=>
      (!res_we && {flag_n_out, flag_v_out, flag_z_out, flag_c_out} ==
                  $past({flag_n_in, flag_v_in, flag_z_in, flag_c_in})));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_we && $stable(res_data) && $stable(flag_z_out)));
endmodule

// File: tb/sim_rmw_flag_unit.sv
module sim_rmw_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] mem_in = '0, acc_in = '0;
  logic       fn = 0, fv = 0, fz = 0, fc = 0;
  logic       res_valid, res_we;
  logic [7:0] res_data;
  logic       on, ov, oz, oc;
  int         vectors = 0;
  int         miscompares = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  rmw_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .mem_in(mem_in), .acc_in(acc_in),
    .flag_n_in(fn), .flag_v_in(fv), .flag_z_in(fz), .flag_c_in(fc),
    .res_valid(res_valid), .res_data(res_data), .res_we(res_we),
    .flag_n_out(on), .flag_v_out(ov), .flag_z_out(oz), .flag_c_out(oc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request, then check outputs in the following cycle
  task automatic run(input string tag, input logic [2:0] op, input logic [7:0] m,
                     input logic [7:0] a, input logic [3:0] fin,
                     input logic [7:0] exp_d, input logic exp_we, input logic [3:0] exp_f);
    @(negedge clk);
    req_valid = 1; req_op = op; mem_in = m; acc_in = a;
    {fn, fv, fz, fc} = fin;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " data"}, res_data, exp_d);
    chk({tag, " we"}, res_we, exp_we);
    chk({tag, " flags NVZC"}, {on, ov, oz, oc}, exp_f);
    @(negedge clk);
    chk({tag, " R2 strobe drops"}, res_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 we", res_we, 0);
    chk("R1 data", res_data, 0);
    chk("R1 flags", {on, ov, oz, oc}, 0);
  endtask

  task automatic t_shl;
    run("R3 shl 0x81", 3'd0, 8'h81, 8'h00, 4'b0100, 8'h02, 1, 4'b0101);
    run("R3 shl 0x80 zero", 3'd0, 8'h80, 8'h00, 4'b0000, 8'h00, 1, 4'b0011);
    run("R3 shl 0x40 neg", 3'd0, 8'h40, 8'h00, 4'b0001, 8'h80, 1, 4'b1000);
  endtask

  task automatic t_ror;
    run("R4 ror 0x01 c0", 3'd1, 8'h01, 8'h00, 4'b0000, 8'h00, 1, 4'b0011);
    run("R4 ror 0x02 c1", 3'd1, 8'h02, 8'h00, 4'b0101, 8'h81, 1, 4'b1100);
  endtask

  task automatic t_dec;
    run("R5 dec wrap 0x00", 3'd2, 8'h00, 8'h00, 4'b0101, 8'hFF, 1, 4'b1101);
    run("R5 dec to zero", 3'd2, 8'h01, 8'h00, 4'b1000, 8'h00, 1, 4'b0010);
  endtask

  task automatic t_inc;
    run("R6 inc wrap 0xFF", 3'd3, 8'hFF, 8'h00, 4'b1100, 8'h00, 1, 4'b0110);
    run("R6 inc 0x7F", 3'd3, 8'h7F, 8'h00, 4'b0011, 8'h80, 1, 4'b1001);
  endtask

  task automatic t_bit;
    run("R7 bit empty AND", 3'd4, 8'hC0, 8'h3F, 4'b0001, 8'hC0, 0, 4'b1111);
    run("R7 bit overlap", 3'd4, 8'h01, 8'h01, 4'b1110, 8'h01, 0, 4'b0000);
  endtask

  task automatic t_undef;
    run("R8 code5", 3'd5, 8'h5A, 8'hFF, 4'b1010, 8'h5A, 0, 4'b1010);
    run("R8 code6", 3'd6, 8'h00, 8'h00, 4'b0101, 8'h00, 0, 4'b0101);
    run("R8 code7", 3'd7, 8'hFF, 8'h00, 4'b1111, 8'hFF, 0, 4'b1111);
  endtask

  task automatic t_hold;
    run("R9 setup inc", 3'd3, 8'h10, 8'h00, 4'b0000, 8'h11, 1, 4'b0000);
    @(negedge clk);
    mem_in = 8'h00; req_op = 3'd2; fz = 1; fn = 1;
    @(negedge clk);
    chk("R9 we low when idle", res_we, 0);
    chk("R9 data held", res_data, 8'h11);
    chk("R9 flags held", {on, ov, oz, oc}, 4'b0000);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_shl;
    t_ror;
    t_dec;
    t_inc;
    t_bit;
    t_undef;
    t_hold;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule